// File: doc/BRIEF.md
# Interline CCD Timing Generator

This block produces every logic-level waveform needed to clock an interline-transfer area-array CCD in progressive-scan mode, all from one master clock. It drives three vertical transfer phases, two horizontal transfer phases, a reset gate that clears the output node once per pixel, and a substrate pulse that acts as an electronic shutter. It also gives a frame-start strobe and a per-pixel valid strobe to the capture logic downstream. Level shifting to the sensor rails, sampling and digitisation happen outside the block.

A frame is a run of lines, and each line is a run of pixel periods. A pixel period lasts `SUBPIX` master clocks. Every line opens with a blanking region, and the vertical clocks move during it. In line 0 the vertical phases carry the photodiode-to-storage transfer pattern. In every later line they step through a six-state shift that moves the stored image down by one row. The horizontal phases then read the pixels out of the line.

Exposure is set in lines through `exp_lines`. The value is sampled only at frame start. Substrate pulses clear the photodiodes in the early lines of the frame, and the last pulse marks the start of integration. With the defaults (944 pixels, 625 lines), a pixel rate of 29.5 MHz gives 50 frames per second.

Top module: `ccd_timing_gen`

## Requirements
- R1: While `rst_n` is low, and for the first two clock edges after it rises, the outputs hold their idle levels: {v1,v2,v3}=110, h1=1, h2=0, rg=0, sub=0, frame_start=0, pix_valid=0.
- R2: `frame_start` is high for one clock on the third rising edge after reset release. It then repeats every NUM_LINES×LINE_PIX×SUBPIX clocks and is low at all other times.
- R3: In readout pixels (pixel index ≥ BLANK_PIX), h1 is high for the first SUBPIX/2 clocks of the pixel and h2 is high for the remaining clocks. h1 and h2 are never high together.
- R4: `rg` is high for exactly the first clock of each readout pixel. It is low throughout blanking.
- R5: Throughout blanking (pixel index < BLANK_PIX), h1=1 and h2=0, including the whole time a vertical sequence is running.
- R6: In lines 1 to NUM_LINES−1, starting at clock VSEQ_PIX×SUBPIX of the line, {v1,v2,v3} passes through 010, 011, 001, 101, 100, 110 in that order. It stays in each state for VSTEP clocks and then returns to idle 110. Outside this window it is 110.
- R7: In line 0 the same window holds {v1,v2,v3}=111 for all 6×VSTEP clocks. This pattern never appears in any other line.
- R8: With E = min(exposure, NUM_LINES−1), `sub` is high for the SUBPIX clocks of pixel SUB_PIX in each line from 1 up to NUM_LINES−1−E, and low everywhere else.
- R9: `exp_lines` is sampled only on the clock where the frame starts. A change during a frame has no effect on `sub` until the next frame.
- R10: `pix_valid` is high for one clock, the last clock of the pixel, for each pixel inside the effective window. The window covers lines 1+V_OFS to V_OFS+EFF_LINES and pixels BLANK_PIX+H_OFS to BLANK_PIX+H_OFS+EFF_PIX−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| exp_lines | input | clog2(NUM_LINES)+1 | Exposure length in lines, sampled at frame start |
| v1 | output | 1 | Vertical transfer phase 1 |
| v2 | output | 1 | Vertical transfer phase 2 |
| v3 | output | 1 | Vertical transfer phase 3 |
| h1 | output | 1 | Horizontal transfer phase 1 |
| h2 | output | 1 | Horizontal transfer phase 2 |
| rg | output | 1 | Reset gate, one pulse per readout pixel |
| sub | output | 1 | Substrate shutter pulse |
| frame_start | output | 1 | One-clock strobe at the start of each frame |
| pix_valid | output | 1 | One-clock strobe per effective pixel |

## Verification
The bench runs a full-exposure frame, a clamped over-range exposure, and exposure changes made in the middle of a frame. A design that samples the exposure continuously would move the last substrate pulse inside the current frame. A design that does not clamp would emit stray pulses or none at all. The bench also checks the edges of the vertical window, where an off-by-one sequencer shortens or stretches a phase state, and it confirms that the transfer pattern appears in line 0 only. Horizontal phases that keep toggling in blanking, a reset gate that fires in blanking, and a valid strobe that slips by one pixel or one line at a window edge all show up as mismatches on the cycle they occur.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef logic [2:0] vphase_t;

  localparam vphase_t V_IDLE = 3'b110;
  localparam vphase_t V_XFER = 3'b111;
  localparam int      V_NSTEP = 6;

  function automatic vphase_t shift_state(input logic [2:0] step);
    vphase_t r;
    case (step)
      3'd0:    r = 3'b010;
      3'd1:    r = 3'b011;
      3'd2:    r = 3'b001;
      3'd3:    r = 3'b101;
      3'd4:    r = 3'b100;
      default: r = 3'b110;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ccd_pos_ctr.sv
module ccd_pos_ctr #(
  parameter int SUBPIX    = 4,
  parameter int LINE_PIX  = 944,
  parameter int NUM_LINES = 625,
  localparam int SW = $clog2(SUBPIX),
  localparam int PW = $clog2(LINE_PIX),
  localparam int LW = $clog2(NUM_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] sub_q,
  output logic [PW-1:0] pix_q,
  output logic [LW-1:0] line_q
);
  localparam logic [SW-1:0] S_LAST = SW'(SUBPIX - 1);
  localparam logic [PW-1:0] P_LAST = PW'(LINE_PIX - 1);
  localparam logic [LW-1:0] L_LAST = LW'(NUM_LINES - 1);

  logic          pix_en, line_en;
  logic [SW-1:0] sub_d;
  logic [PW-1:0] pix_d;
  logic [LW-1:0] line_d;

  always_comb begin
    pix_en  = (sub_q == S_LAST);
    line_en = pix_en && (pix_q == P_LAST);
    sub_d   = pix_en ? '0 : sub_q + 1'b1;
    pix_d   = pix_q;
    if (pix_en) pix_d = (pix_q == P_LAST) ? '0 : pix_q + 1'b1;
    line_d  = line_q;
    if (line_en) line_d = (line_q == L_LAST) ? '0 : line_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      sub_q <= sub_d;
      if (pix_en)  pix_q  <= pix_d;
      if (line_en) line_q <= line_d;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_q <= P_LAST) && (line_q <= L_LAST)) else $error("position out of range"); // R2

endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq
  import ccd_tg_pkg::*;
#(
  parameter int SUBPIX    = 4,
  parameter int LINE_PIX  = 944,
  parameter int NUM_LINES = 625,
  parameter int VSEQ_PIX  = 8,
  parameter int VSTEP     = 8,
  localparam int SW = $clog2(SUBPIX),
  localparam int PW = $clog2(LINE_PIX),
  localparam int LW = $clog2(NUM_LINES),
  localparam int CW = (VSTEP > 1) ? $clog2(VSTEP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sub_q,
  input  logic [PW-1:0] pix_q,
  input  logic [LW-1:0] line_q,
  output vphase_t       v_q
);
  localparam logic [PW-1:0] START_P   = PW'(VSEQ_PIX);
  localparam logic [CW-1:0] CNT_LAST  = CW'(VSTEP - 1);
  localparam logic [2:0]    STEP_LAST = 3'(V_NSTEP - 1);

  logic          busy_q, busy_d;
  logic          xfer_q, xfer_d;
  logic [2:0]    step_q, step_d;
  logic [CW-1:0] cnt_q, cnt_d;
  vphase_t       v_d;
  logic          trig;

  always_comb begin
    trig   = (pix_q == START_P) && (sub_q == '0);
    busy_d = busy_q;
    xfer_d = xfer_q;
    step_d = step_q;
    cnt_d  = cnt_q;
    if (trig) begin
      busy_d = 1'b1;
      xfer_d = (line_q == '0);
      step_d = '0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_d = '0;
        if (step_q == STEP_LAST) busy_d = 1'b0;
        else                     step_d = step_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (!busy_d)     v_d = V_IDLE;
    else if (xfer_d) v_d = V_XFER;
    else             v_d = shift_state(step_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      xfer_q <= 1'b0;
      step_q <= '0;
      cnt_q  <= '0;
      v_q    <= V_IDLE;
    end else begin
      busy_q <= busy_d;
      xfer_q <= xfer_d;
      step_q <= step_d;
      cnt_q  <= cnt_d;
      v_q    <= v_d;
    end
  end

  AST_V_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(v_q ^ $past(v_q)) <= 1) else $error("two vertical phases moved at once"); // R6
  AST_XFER_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q == V_XFER) |-> xfer_q) else $error("transfer pattern outside line 0"); // R7

endmodule

// File: rtl/ccd_hdrv.sv
module ccd_hdrv #(
  parameter int SUBPIX    = 4,
  parameter int LINE_PIX  = 944,
  parameter int BLANK_PIX = 80,
  localparam int SW = $clog2(SUBPIX),
  localparam int PW = $clog2(LINE_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sub_q,
  input  logic [PW-1:0] pix_q,
  output logic          h1_q,
  output logic          h2_q,
  output logic          rg_q
);
  localparam logic [PW-1:0] BLANK_P = PW'(BLANK_PIX);
  localparam logic [SW-1:0] HALF_S  = SW'(SUBPIX / 2);

  logic readout, first_half;
  logic h1_d, h2_d, rg_d;

  always_comb begin
    readout    = (pix_q >= BLANK_P);
    first_half = (sub_q < HALF_S);
    h1_d = readout ? first_half : 1'b1;
    h2_d = readout && !first_half;
    rg_d = readout && (sub_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1_q <= 1'b1;
      h2_q <= 1'b0;
      rg_q <= 1'b0;
    end else begin
      h1_q <= h1_d;
      h2_q <= h2_d;
      rg_q <= rg_d;
    end
  end

  AST_H_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(h1_q && h2_q)) else $error("h1 and h2 overlap"); // R3
  AST_RG_IN_H1: assert property (@(posedge clk) disable iff (!rst_n)
    rg_q |=> !rg_q) else $error("reset gate wider than one clock"); // R4

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_tg_pkg::*;
#(
  parameter int SUBPIX    = 4,
  parameter int LINE_PIX  = 944,
  parameter int NUM_LINES = 625,
  parameter int BLANK_PIX = 80,
  parameter int VSEQ_PIX  = 8,
  parameter int VSTEP     = 8,
  parameter int SUB_PIX   = 30,
  parameter int H_OFS     = 40,
  parameter int EFF_PIX   = 782,
  parameter int V_OFS     = 20,
  parameter int EFF_LINES = 582,
  localparam int SW = $clog2(SUBPIX),
  localparam int PW = $clog2(LINE_PIX),
  localparam int LW = $clog2(NUM_LINES),
  localparam int EW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] exp_lines,
  output logic          v1,
  output logic          v2,
  output logic          v3,
  output logic          h1,
  output logic          h2,
  output logic          rg,
  output logic          sub,
  output logic          frame_start,
  output logic          pix_valid
);
  localparam logic [EW-1:0]   E_MAX   = EW'(NUM_LINES - 1);
  localparam logic [EW-1:0]   N_LINES = EW'(NUM_LINES);
  localparam logic [PW-1:0]   SUB_P   = PW'(SUB_PIX);
  localparam logic [SW-1:0]   S_LAST  = SW'(SUBPIX - 1);
  localparam logic [EW-1:0]   VAL_L0  = EW'(1 + V_OFS);
  localparam logic [EW-1:0]   VAL_L1  = EW'(1 + V_OFS + EFF_LINES);
  localparam logic [PW:0]     VAL_P0  = (PW+1)'(BLANK_PIX + H_OFS);
  localparam logic [PW:0]     VAL_P1  = (PW+1)'(BLANK_PIX + H_OFS + EFF_PIX);

  logic          rs1_q, rst_q;
  logic [SW-1:0] sub_cnt;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;
  vphase_t       v_q;
  logic          h1_q, h2_q, rg_q;

  logic [EW-1:0] exp_q, exp_d, e_clamp, sub_lim;
  logic          at_frame, sub_d, fs_d, pv_d;
  logic          sub_q, fs_q, pv_q;
  logic [EW-1:0] line_x;
  logic [PW:0]   pix_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_q <= rs1_q;
    end
  end

  ccd_pos_ctr #(.SUBPIX(SUBPIX), .LINE_PIX(LINE_PIX), .NUM_LINES(NUM_LINES)) u_pos (
    .clk(clk), .rst_n(rst_q), .sub_q(sub_cnt), .pix_q(pix_cnt), .line_q(line_cnt));

  ccd_vseq #(.SUBPIX(SUBPIX), .LINE_PIX(LINE_PIX), .NUM_LINES(NUM_LINES),
             .VSEQ_PIX(VSEQ_PIX), .VSTEP(VSTEP)) u_vseq (
    .clk(clk), .rst_n(rst_q), .sub_q(sub_cnt), .pix_q(pix_cnt), .line_q(line_cnt), .v_q(v_q));

  ccd_hdrv #(.SUBPIX(SUBPIX), .LINE_PIX(LINE_PIX), .BLANK_PIX(BLANK_PIX)) u_hdrv (
    .clk(clk), .rst_n(rst_q), .sub_q(sub_cnt), .pix_q(pix_cnt),
    .h1_q(h1_q), .h2_q(h2_q), .rg_q(rg_q));

  always_comb begin
    at_frame = (line_cnt == '0) && (pix_cnt == '0) && (sub_cnt == '0);
    exp_d    = at_frame ? exp_lines : exp_q;
    e_clamp  = (exp_q > E_MAX) ? E_MAX : exp_q;
    sub_lim  = N_LINES - e_clamp;
    line_x   = {{(EW-LW){1'b0}}, line_cnt};
    pix_x    = {1'b0, pix_cnt};
    sub_d    = (line_cnt != '0) && (line_x < sub_lim) && (pix_cnt == SUB_P);
    fs_d     = at_frame;
    pv_d     = (line_x >= VAL_L0) && (line_x < VAL_L1) &&
               (pix_x >= VAL_P0) && (pix_x < VAL_P1) && (sub_cnt == S_LAST);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      exp_q <= '0;
      sub_q <= 1'b0;
      fs_q  <= 1'b0;
      pv_q  <= 1'b0;
    end else begin
      if (at_frame) exp_q <= exp_d;
      sub_q <= sub_d;
      fs_q  <= fs_d;
      pv_q  <= pv_d;
    end
  end

  assign {v1, v2, v3} = v_q;
  assign h1          = h1_q;
  assign h2          = h2_q;
  assign rg          = rg_q;
  assign sub         = sub_q;
  assign frame_start = fs_q;
  assign pix_valid   = pv_q;

  AST_H_HOLD_VSHIFT: assert property (@(posedge clk) disable iff (!rst_q)
    (v_q != V_IDLE) |-> (h1_q && !h2_q && !rg_q)) else $error("horizontal moved during vertical"); // R5
  AST_SUB_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_q)
    sub_q |-> (h1_q && !h2_q && !rg_q)) else $error("substrate pulse in readout"); // R8
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_q)
    fs_q |=> !fs_q) else $error("frame strobe wider than one clock"); // R2
  AST_PV_IN_H2: assert property (@(posedge clk) disable iff (!rst_q)
    pv_q |-> (h2_q && !h1_q)) else $error("valid strobe outside pixel end"); // R10

endmodule

// File: tb/tb_ccd_timing_gen.sv
`timescale 1ns/1ps
module tb_ccd_timing_gen;
  localparam int SUBPIX = 4, LINE_PIX = 24, NUM_LINES = 8, BLANK_PIX = 8;
  localparam int VSEQ_PIX = 1, VSTEP = 3, SUB_PIX = 6;
  localparam int H_OFS = 2, EFF_PIX = 10, V_OFS = 1, EFF_LINES = 5;
  localparam int EW = $clog2(NUM_LINES) + 1;
  localparam int LCLK = LINE_PIX * SUBPIX;
  localparam int FR = NUM_LINES * LCLK;

  logic clk, rst_n;
  logic [EW-1:0] exp_in;
  logic v1, v2, v3, h1, h2, rg, sub, fs, pv;

  int compared = 0, mismatched = 0;
  int mexp = 0;
  bit done = 0;

  ccd_timing_gen #(.SUBPIX(SUBPIX), .LINE_PIX(LINE_PIX), .NUM_LINES(NUM_LINES),
    .BLANK_PIX(BLANK_PIX), .VSEQ_PIX(VSEQ_PIX), .VSTEP(VSTEP), .SUB_PIX(SUB_PIX),
    .H_OFS(H_OFS), .EFF_PIX(EFF_PIX), .V_OFS(V_OFS), .EFF_LINES(EFF_LINES)) dut (
    .clk(clk), .rst_n(rst_n), .exp_lines(exp_in), .v1(v1), .v2(v2), .v3(v3),
    .h1(h1), .h2(h2), .rg(rg), .sub(sub), .frame_start(fs), .pix_valid(pv));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam logic [8:0] IDLE = 9'b110_100_000;

  // Expected {v1,v2,v3,h1,h2,rg,sub,fs,pv} at frame position t
  function automatic logic [8:0] model(input int t, input int e);
    int l, c, p, s, w, ec;
    logic [2:0] vv;
    logic hh1, hh2, rr, ss, ff, vp, act;
    l = (t / LCLK) % NUM_LINES;
    c = t % LCLK;
    p = c / SUBPIX;
    s = c % SUBPIX;
    act = (p >= BLANK_PIX);
    hh1 = act ? (s < SUBPIX / 2) : 1'b1;
    hh2 = act && (s >= SUBPIX / 2);
    rr  = act && (s == 0);
    w = c - VSEQ_PIX * SUBPIX;
    vv = 3'b110;
    if (w >= 0 && w < 6 * VSTEP) begin
      if (l == 0) vv = 3'b111;
      else case (w / VSTEP)
        0: vv = 3'b010; 1: vv = 3'b011; 2: vv = 3'b001;
        3: vv = 3'b101; 4: vv = 3'b100; default: vv = 3'b110;
      endcase
    end
    ec = (e > NUM_LINES - 1) ? NUM_LINES - 1 : e;
    ss = (l >= 1) && (l < NUM_LINES - ec) && (p == SUB_PIX);
    ff = (t % FR == 0);
    vp = (l >= 1 + V_OFS) && (l < 1 + V_OFS + EFF_LINES) &&
         (p >= BLANK_PIX + H_OFS) && (p < BLANK_PIX + H_OFS + EFF_PIX) && (s == SUBPIX - 1);
    return {vv, hh1, hh2, rr, ss, ff, vp};
  endfunction

  function automatic string tag_of(input int b, input int t, input bit rst_phase);
    int l, p;
    if (rst_phase) return "R1";
    l = (t / LCLK) % NUM_LINES;
    p = (t % LCLK) / SUBPIX;
    case (b)
      8, 7, 6: return (l == 0) ? "R7" : "R6";
      5, 4:    return (p >= BLANK_PIX) ? "R3" : "R5";
      3:       return "R4";
      2:       return "R8";   // exposure latching of R9 also lands here
      1:       return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic [8:0] exp_v, input int t, input bit rst_phase);
    logic [8:0] act;
    act = {v1, v2, v3, h1, h2, rg, sub, fs, pv};
    for (int b = 0; b < 9; b++) begin
      compared++;
      if (act[b] !== exp_v[b]) begin
        mismatched++;
        $display("FAIL %s bit%0d t=%0d actual=%b expected=%b", tag_of(b, t, rst_phase),
                 b, t, act[b], exp_v[b]);
      end
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    exp_in = '0;
    repeat (5) begin
      @(negedge clk);
      check(IDLE, 0, 1'b1);       // R1 during reset
    end
    rst_n = 1'b1;
    for (int k = 1; k <= 3 + 5 * FR + 50; k++) begin
      int t;
      @(posedge clk);
      t = k - 3;
      if (t >= 0 && t % FR == 0) mexp = int'(exp_in);   // R9 sample point
      @(negedge clk);
      if (t < 0) check(IDLE, 0, 1'b1);                  // R1 after release
      else       check(model(t, mexp), t, 1'b0);
      if (t >= 0 && t % FR == FR / 2) begin             // R9 mid-frame change
        case (t / FR)
          0: exp_in = EW'(3);
          1: exp_in = EW'(7);
          2: exp_in = EW'(5);
          default: exp_in = EW'(10);   // over range, clamps (R8)
        endcase
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule